// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM command bus and walks the memory from power-up to the all-banks-idle, ready state. While the supplies and clock settle it keeps the clock-enable pin low and the chip deselected, so the memory's data and strobe pins stay in high impedance. Once the power-good and clock-stable input has stayed high for a programmable interval, it raises clock enable and sends a fixed series of commands. The series precharges all banks, enables the DLL through the extended mode register, and loads the mode register with a DLL reset. It then precharges again, performs two auto refreshes, and loads the mode register a second time without the DLL reset.

Each command occupies the bus for exactly one clock. NOP cycles fill the space between commands so that precharge, mode-load and refresh recovery times are met. These times are parameters counted in clocks. The power-up wait is derived from the clock frequency in MHz and the wait in microseconds. When the last mode load has settled and the DLL lock interval has run out, the block raises `init_done` and keeps the bus parked on NOP with clock enable high, so a normal-operation controller can take the bus over. There is no streaming data path: every pin is a plain control or status signal.

Top module: `ddr_init_seq`

## Requirements
- R1: During reset and throughout the power-up wait, `cke` is low, the bus is deselected (`cs_n`, `ras_n`, `cas_n`, `we_n` all 1), `ba` and `addr` are zero and `init_done` is low.
- R2: `cke` goes high on the (CLK_MHZ*PWRUP_US+1)-th consecutive rising edge at which `pwr_ok` is sampled high. Any cycle with `pwr_ok` low restarts the count.
- R3: The first cycle with `cke` high carries a NOP, and the next cycle carries a PRECHARGE ALL.
- R4: After that first PRECHARGE ALL, the bus carries exactly these commands in this order, then nothing else: a mode load with `ba`=2'b01 and `addr`=EXT_MODE, a mode load with `ba`=2'b00 and the DLL-reset bit set, a PRECHARGE ALL, two AUTO REFRESH, and a mode load with `ba`=2'b00 and the DLL-reset bit clear.
- R5: A mode-register word places the burst-length code in `addr[2:0]`, the burst type (1 = interleaved) in `addr[3]`, the CAS-latency code in `addr[6:4]` and the operating mode in `addr[12:7]`. The DLL reset is `addr[8]`, and all other operating-mode bits are zero.
- R6: Command encodings as {`cs_n`,`ras_n`,`cas_n`,`we_n`}: NOP = 0111, PRECHARGE = 0010 with `addr[10]`=1 (all banks), AUTO REFRESH = 0001, mode load = 0000.
- R7: The distance from a command to the next one is T_RP clocks after a PRECHARGE ALL, T_MRD after a mode load and T_RFC after an AUTO REFRESH. Every cycle in between is a NOP, and each of these parameters is at least 2.
- R8: `init_done` rises exactly max(T_MRD after the final mode load, DLL_LOCK after the DLL-reset mode load) clocks after the command that sets it.
- R9: Once `init_done` is high it stays high until reset.
- R10: While `init_done` is high, the bus carries NOP with `cke` high.
- R11: Once `cke` has risen it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supplies and clock stable |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address / mode word |
| init_done | output | 1 | Initialization complete, bus free |

## Verification
The bench drops `pwr_ok` partway through the power-up wait. A design that fails to restart its count raises `cke` hundreds of cycles early, and the exact edge count of R2 exposes this. A scoreboard checks each command against the expected one, including its bank bits, mode word and distance from the previous command. A swapped bank-select, a misplaced DLL-reset bit or an off-by-one gap counter therefore shows up on the first wrong command. The DLL lock interval is set longer than the tail of the sequence. A design that raised `init_done` on the mode-load recovery alone would finish far too early, and one that counted the lock interval from the wrong command would finish late. A second run holds `pwr_ok` high through reset, which catches a counter that only starts on a rising `pwr_ok`.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    STP_PWRUP,
    STP_WAKE,
    STP_PREA1,
    STP_EMR,
    STP_MR_RST,
    STP_PREA2,
    STP_REF1,
    STP_REF2,
    STP_MR_RUN,
    STP_DONE
  } step_e;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_LMR
  } cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam int unsigned MODE_W   = 13;
  localparam int unsigned PREA_BIT = 10;

  // operating-mode field values (addr[12:7])
  localparam logic [5:0] OPM_RUN     = 6'b000000;
  localparam logic [5:0] OPM_DLL_RST = 6'b000010;

  function automatic logic [MODE_W-1:0] mode_word(
    input logic [2:0] bl_code,
    input logic       bt_ilv,
    input logic [2:0] cl_code,
    input logic [5:0] opmode
  );
    return {opmode, cl_code, bt_ilv, bl_code};
  endfunction

endpackage

// File: rtl/ddr_init_cnt.sv
module ddr_init_cnt #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= INIT;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
(
  input  logic  sel,
  input  cmd_e  cmd,
  output pins_t pins
);

  always_comb begin
    if (!sel) begin
      pins = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    end else begin
      unique case (cmd)
        CMD_PRE: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
        CMD_REF: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
        CMD_LMR: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
        default: pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      endcase
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 200,
  parameter int unsigned PWRUP_US   = 200,
  parameter int unsigned T_RP       = 3,
  parameter int unsigned T_MRD      = 2,
  parameter int unsigned T_RFC      = 14,
  parameter int unsigned DLL_LOCK   = 200,
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned BA_W       = 2,
  parameter logic [2:0]  BURST_CODE = 3'b010,
  parameter logic        BURST_ILV  = 1'b0,
  parameter logic [2:0]  CAS_CODE   = 3'b010,
  parameter logic [12:0] EXT_MODE   = 13'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int unsigned PU_CYC  = CLK_MHZ * PWRUP_US;
  localparam int unsigned PU_W    = $clog2(PU_CYC + 1);
  localparam int unsigned GAP_A   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int unsigned GAP_MAX = (GAP_A > T_RFC) ? GAP_A : T_RFC;
  localparam int unsigned GAP_W   = $clog2(GAP_MAX + 1);
  localparam int unsigned DLL_W   = $clog2(DLL_LOCK + 1);

  localparam logic [MODE_W-1:0] MR_RST_WORD = mode_word(BURST_CODE, BURST_ILV, CAS_CODE, OPM_DLL_RST);
  localparam logic [MODE_W-1:0] MR_RUN_WORD = mode_word(BURST_CODE, BURST_ILV, CAS_CODE, OPM_RUN);
  localparam logic [ADDR_W-1:0] PREA_ADDR   = ADDR_W'(1) << PREA_BIT;

  step_e               stp_q;
  step_e               nxt_c;
  cmd_e                cmd_c;
  logic [BA_W-1:0]     ba_c;
  logic [ADDR_W-1:0]   addr_c;
  logic [GAP_W-1:0]    gap_c;
  logic                cmd_step;
  logic                issue;
  logic                gap_z;
  logic                pu_z;
  logic                dll_z;
  logic                dll_armed_q;
  logic                cke_q;
  logic                done_q;
  pins_t               enc_pins;
  pins_t               bus_q;
  logic [BA_W-1:0]     ba_q;
  logic [ADDR_W-1:0]   addr_q;

  // step table: command, bank, address, spacing to next command, successor
  always_comb begin
    cmd_c    = CMD_NOP;
    ba_c     = '0;
    addr_c   = '0;
    gap_c    = GAP_W'(1);
    nxt_c    = stp_q;
    cmd_step = 1'b1;
    unique case (stp_q)
      STP_WAKE: begin
        nxt_c = STP_PREA1;
      end
      STP_PREA1, STP_PREA2: begin
        cmd_c  = CMD_PRE;
        addr_c = PREA_ADDR;
        gap_c  = GAP_W'(T_RP);
        nxt_c  = (stp_q == STP_PREA1) ? STP_EMR : STP_REF1;
      end
      STP_EMR: begin
        cmd_c  = CMD_LMR;
        ba_c   = BA_W'(1);
        addr_c = ADDR_W'(EXT_MODE);
        gap_c  = GAP_W'(T_MRD);
        nxt_c  = STP_MR_RST;
      end
      STP_MR_RST: begin
        cmd_c  = CMD_LMR;
        addr_c = ADDR_W'(MR_RST_WORD);
        gap_c  = GAP_W'(T_MRD);
        nxt_c  = STP_PREA2;
      end
      STP_REF1, STP_REF2: begin
        cmd_c = CMD_REF;
        gap_c = GAP_W'(T_RFC);
        nxt_c = (stp_q == STP_REF1) ? STP_REF2 : STP_MR_RUN;
      end
      STP_MR_RUN: begin
        cmd_c  = CMD_LMR;
        addr_c = ADDR_W'(MR_RUN_WORD);
        gap_c  = GAP_W'(T_MRD);
        nxt_c  = STP_DONE;
      end
      default: begin
        cmd_step = 1'b0;
      end
    endcase
  end

  assign issue = cmd_step && gap_z;

  ddr_init_cnt #(.W(PU_W), .INIT(PU_W'(PU_CYC - 1))) u_pu_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (!pwr_ok && (stp_q == STP_PWRUP)),
    .load_val (PU_W'(PU_CYC - 1)),
    .dec      (stp_q == STP_PWRUP),
    .zero     (pu_z)
  );

  ddr_init_cnt #(.W(GAP_W), .INIT('0)) u_gap_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue),
    .load_val (gap_c - 1'b1),
    .dec      (1'b1),
    .zero     (gap_z)
  );

  ddr_init_cnt #(.W(DLL_W), .INIT('0)) u_dll_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue && (stp_q == STP_MR_RST)),
    .load_val (DLL_W'(DLL_LOCK - 1)),
    .dec      (1'b1),
    .zero     (dll_z)
  );

  ddr_init_cmd_enc u_enc (
    .sel  (stp_q != STP_PWRUP),
    .cmd  (issue ? cmd_c : CMD_NOP),
    .pins (enc_pins)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stp_q       <= STP_PWRUP;
      cke_q       <= 1'b0;
      bus_q       <= '1;
      ba_q        <= '0;
      addr_q      <= '0;
      dll_armed_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      cke_q  <= (stp_q != STP_PWRUP);
      bus_q  <= enc_pins;
      ba_q   <= issue ? ba_c : '0;
      addr_q <= issue ? addr_c : '0;
      if (stp_q == STP_PWRUP) begin
        if (pwr_ok && pu_z) stp_q <= STP_WAKE;
      end else if (issue) begin
        stp_q <= nxt_c;
      end
      if (issue && (stp_q == STP_MR_RST)) dll_armed_q <= 1'b1;
      if ((stp_q == STP_DONE) && gap_z && dll_armed_q && dll_z) done_q <= 1'b1;
    end
  end

  assign cke       = cke_q;
  assign cs_n      = bus_q.cs_n;
  assign ras_n     = bus_q.ras_n;
  assign cas_n     = bus_q.cas_n;
  assign we_n      = bus_q.we_n;
  assign ba        = ba_q;
  assign addr      = addr_q;
  assign init_done = done_q;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_ok,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);

  logic is_nop;
  logic is_cmd;
  logic is_pre;

  assign is_nop = !cs_n && ras_n && cas_n && we_n;
  assign is_cmd = !cs_n && !(ras_n && cas_n && we_n);
  assign is_pre = !cs_n && !ras_n && cas_n && !we_n;

  p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cs_n && !init_done));

  p_cke_needs_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cke) && cke) |-> $past(pwr_ok));

  p_prea_all_banks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && is_pre) |-> addr[10]);

  p_cmd_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && is_cmd) |=> is_nop);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_done_bus_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cke && is_nop));

  p_cke_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_ok    (pwr_ok),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .addr      (addr),
  .init_done (init_done)
);

// File: tb/ddr_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_init_seq_tb_top;

  localparam int unsigned CLK_MHZ  = 200;
  localparam int unsigned PWRUP_US = 2;
  localparam int          PU       = CLK_MHZ * PWRUP_US;
  localparam int          T_RP     = 3;
  localparam int          T_MRD    = 2;
  localparam int          T_RFC    = 9;
  localparam int          DLL      = 200;
  localparam logic [2:0]  BL       = 3'b011;
  localparam logic        BT       = 1'b1;
  localparam logic [2:0]  CL       = 3'b010;
  localparam logic [12:0] EXT      = 13'h0042;

  // expected mode words from the R5 field layout
  localparam logic [12:0] MR_RST = 13'((1 << 8) | (int'(CL) << 4) | (int'(BT) << 3) | int'(BL));
  localparam logic [12:0] MR_RUN = 13'((int'(CL) << 4) | (int'(BT) << 3) | int'(BL));

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pwr_ok;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0]  ba;
  logic [12:0] addr;

  always #2.5 clk = ~clk;

  ddr_init_seq #(
    .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .T_RP(T_RP), .T_MRD(T_MRD),
    .T_RFC(T_RFC), .DLL_LOCK(DLL), .ADDR_W(13), .BA_W(2),
    .BURST_CODE(BL), .BURST_ILV(BT), .CAS_CODE(CL), .EXT_MODE(EXT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .init_done(init_done)
  );

  typedef enum int {K_PRE, K_REF, K_LMR} kind_e;
  typedef struct {
    kind_e       kind;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic [12:0] mask;
    int          gap;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push(input kind_e k, input logic [1:0] b, input logic [12:0] a,
                      input logic [12:0] m, input int g, input string r);
    exp_t e;
    e.kind = k; e.ba = b; e.addr = a; e.mask = m; e.gap = g; e.req = r;
    exp_q.push_back(e);
  endtask

  // driver side of the scoreboard: the expected command stream
  task automatic load_expected();
    exp_q.delete();
    push(K_PRE, 2'b00, 13'h0400, 13'h0400, 1,     "R3");
    push(K_LMR, 2'b01, EXT,      13'h1fff, T_RP,  "R4");
    push(K_LMR, 2'b00, MR_RST,   13'h1fff, T_MRD, "R5");
    push(K_PRE, 2'b00, 13'h0400, 13'h0400, T_MRD, "R6");
    push(K_REF, 2'b00, 13'h0000, 13'h0000, T_RP,  "R7");
    push(K_REF, 2'b00, 13'h0000, 13'h0000, T_RFC, "R7");
    push(K_LMR, 2'b00, MR_RUN,   13'h1fff, T_RFC, "R5");
  endtask

  // monitor side
  int pu_cnt, cyc, last_cmd, rst_cyc, run_cyc;
  bit seen_cke, done_seen;

  always @(negedge clk) begin
    if (!rst_n) begin
      pu_cnt = 0; cyc = 0; last_cmd = 0; rst_cyc = -1; run_cyc = -1;
      seen_cke = 1'b0; done_seen = 1'b0;
    end else begin
      automatic bit is_nop = !cs_n && ras_n && cas_n && we_n;
      automatic bit is_pre = !cs_n && !ras_n && cas_n && !we_n;
      automatic bit is_ref = !cs_n && !ras_n && !cas_n && we_n;
      automatic bit is_lmr = !cs_n && !ras_n && !cas_n && !we_n;
      if (!cke) begin
        if (seen_cke) chk(1'b0, "R11", "cke fell after rising", 0, 1);
        chk(cs_n && ras_n && cas_n && we_n && !init_done && addr == 0, "R1",
            "deselect while cke low", {cs_n, ras_n, cas_n, we_n, init_done}, 5'b11110);
        if (pwr_ok) pu_cnt++; else pu_cnt = 0;
      end else if (!seen_cke) begin
        seen_cke = 1'b1; cyc = 0; last_cmd = 0;
        chk(pu_cnt == PU + 1, "R2", "edges with pwr_ok high before cke", pu_cnt, PU + 1);
        chk(is_nop, "R3", "first cke-high cycle is NOP", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
      end else begin
        cyc++;
        if (init_done) begin
          if (!done_seen) begin
            automatic int e1 = run_cyc + T_MRD;
            automatic int e2 = rst_cyc + DLL;
            automatic int ex = (e1 > e2) ? e1 : e2;
            done_seen = 1'b1;
            chk(rst_cyc >= 0 && run_cyc >= 0 && cyc == ex, "R8", "init_done cycle", cyc, ex);
            chk(exp_q.size() == 0, "R4", "commands missing at done", exp_q.size(), 0);
          end
          chk(is_nop, "R10", "bus after done", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        end else begin
          if (done_seen) chk(1'b0, "R9", "init_done fell", 0, 1);
          if (!is_nop) begin
            if (!(is_pre || is_ref || is_lmr)) begin
              chk(1'b0, "R6", "unknown command", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
            end else if (exp_q.size() == 0) begin
              chk(1'b0, "R4", "extra command", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
            end else begin
              automatic exp_t e = exp_q.pop_front();
              automatic kind_e k = is_pre ? K_PRE : (is_ref ? K_REF : K_LMR);
              chk(k == e.kind, e.req, "command kind", k, e.kind);
              chk((addr & e.mask) == (e.addr & e.mask), e.req, "address", addr, e.addr);
              if (e.kind == K_LMR) chk(ba == e.ba, e.req, "bank bits", ba, e.ba);
              chk(cyc - last_cmd == e.gap, "R7", "command spacing", cyc - last_cmd, e.gap);
              last_cmd = cyc;
              if (is_lmr && ba == 2'b00 && addr[8]) rst_cyc = cyc;
              else if (is_lmr && ba == 2'b00) run_cyc = cyc;
            end
          end
        end
      end
    end
  end

  task automatic wait_done();
    int n = 0;
    while (!init_done && n < 3000) begin
      @(posedge clk);
      n++;
    end
    chk(init_done, "R8", "init_done reached", init_done, 1);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    rst_n  = 1'b0;
    pwr_ok = 1'b0;
    load_expected();
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!cke && cs_n && !init_done && ba == 0, "R1", "state in reset", cke, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(!cke, "R2", "no wake without pwr_ok", cke, 0);
    // partial wait, then a drop that must restart the count
    @(posedge clk); #1 pwr_ok = 1'b1;
    repeat (150) @(posedge clk);
    #1 pwr_ok = 1'b0;
    @(negedge clk);
    chk(!cke, "R2", "cke low after partial wait", cke, 0);
    repeat (3) @(posedge clk);
    #1 pwr_ok = 1'b1;
    wait_done();
    repeat (40) @(posedge clk);
    chk(exp_q.size() == 0, "R4", "all commands seen, run 1", exp_q.size(), 0);
    chk(cke && init_done, "R9", "still done after idle", init_done, 1);

    // second run: pwr_ok already high across reset
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    load_expected();
    @(negedge clk);
    chk(!cke && !init_done && cs_n, "R1", "state in second reset", cke, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    wait_done();
    repeat (20) @(posedge clk);
    chk(exp_q.size() == 0, "R4", "all commands seen, run 2", exp_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule